// File: doc/BRIEF.md
# Pad Calibration Control Sequencer

This block is the host-facing register file and sequencer for a serial-link pad impedance calibration engine. Software programs bias settings, per-pad select bits and offset codes, and then sets a start bit. The block counts a fixed-length code sequence on a prescaled timer. It then waits until the pads report idle, moves the offset codes of every selected pad onto its code outputs, drops the active flag and raises a sticky done flag.

Registers are 32 bits wide and addressed by byte. The register index is `bus_addr[7:2]`, and bits 1:0 are ignored. Reads are combinational. Only the fields listed below can be stored. All other bits, and all unmapped indices, read as zero.

Top module: `padcal_seq`

## Requirements
- R1: After reset, every register reads 0 except bias-0 (index 0x16) and bias-2 (index 0x18), which read 0x00000002. At the ports, `clamp_pd`=1, `reg_pd`=1, `cal_active`=0 and `cal_done`=0.
- R2: The writable fields read back exactly as written, with all other bits at 0. The masks are: control (index 0) 0x3F000010, bias-0 0x00000003, bias-1 (0x17) 0x00070700, bias-2 0x00070072, data-lane pads (indices 0x05–0x0A and 0x0E–0x11, pads 0–9 in that order) 0x003F1F1F, clock-lane pads (0x19–0x1D, pads 0–4) 0x00201F1F. Unmapped indices read 0.
- R3: A control write with bit 0 set while idle raises `cal_active` in the next cycle. Bit 0 always reads back as 0.
- R4: With `pads_idle` held at 1, `cal_active` stays high for exactly 2^P × SEQ_TICKS + 1 cycles, where P is control bits 25:24.
- R5: When the code sequence ends while `pads_idle` is 0, `cal_active` stays high. It falls one cycle after `pads_idle` is seen at 1.
- R6: The status register (index 2) shows active in bit 0 and done in bit 16. Done is set when a run finishes and stays set. Writing 1 to bit 16 clears it, and writing 0 there leaves it unchanged.
- R7: A start written while `cal_active` is 1 is ignored and does not lengthen the run.
- R8: When a run finishes, each data pad whose bit 21 is set drives `{bits 20:16, 12:8, 4:0}` on its 15-bit `data_code` slice. An unselected pad keeps its previous code. `data_sel` follows bit 21.
- R9: Clock-lane pads follow the same rule, with a 10-bit code `{bits 12:8, 4:0}` and the select bit at bit 21.
- R10: Bias and control fields drive their outputs directly. Bias-0 bit 0 drives `clamp_ref_en` and bit 1 drives `clamp_pd`. Bias-1 bits 18:16 drive `drv_dn` and bits 10:8 drive `drv_up`. Bias-2 bits 18:16 drive `clamp_lvl`, bits 6:4 drive `aux_lvl` and bit 1 drives `reg_pd`. Control bits 29:26 drive `filt_len` and bit 4 drives `clk_force`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pads_idle | input | 1 | Pads report idle |
| cal_active | output | 1 | Calibration running |
| cal_done | output | 1 | Sticky completion flag |
| filt_len | output | 4 | Noise-filter setting |
| clk_force | output | 1 | Clock-enable override |
| clamp_pd | output | 1 | Clamp power-down |
| clamp_ref_en | output | 1 | Clamp reference enable |
| reg_pd | output | 1 | Regulator power-down |
| clamp_lvl | output | 3 | Clamp level |
| aux_lvl | output | 3 | Aux level |
| drv_dn | output | 3 | Pull-down drive reference |
| drv_up | output | 3 | Pull-up drive reference |
| data_sel | output | 10 | Data pad select bits |
| data_code | output | 150 | Applied data pad codes, 15 bits per pad |
| clk_sel | output | 5 | Clock pad select bits |
| clk_code | output | 50 | Applied clock pad codes, 10 bits per pad |

## Verification
A wrong prescale or sequence counter appears directly as the length of the `cal_active` pulse. The bench therefore measures that length to the exact cycle for several prescale values. A fault in the apply logic leaves a wrong code on a pad slice. This is visible in the cycle after `cal_active` falls, so every pad is compared after each run against a model that holds the previous codes. A fault in the done flag appears on the next status read.

// File: rtl/padcal_seq.sv
module padcal_seq #(
  parameter int SEQ_TICKS = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic [7:0]   bus_addr,
  input  logic [31:0]  bus_wdata,
  output logic [31:0]  bus_rdata,
  input  logic         pads_idle,
  output logic         cal_active,
  output logic         cal_done,
  output logic [3:0]   filt_len,
  output logic         clk_force,
  output logic         clamp_pd,
  output logic         clamp_ref_en,
  output logic         reg_pd,
  output logic [2:0]   clamp_lvl,
  output logic [2:0]   aux_lvl,
  output logic [2:0]   drv_dn,
  output logic [2:0]   drv_up,
  output logic [9:0]   data_sel,
  output logic [149:0] data_code,
  output logic [4:0]   clk_sel,
  output logic [49:0]  clk_code
);
  localparam int ND = 10;
  localparam int NC = 5;
  localparam int CW = $clog2(SEQ_TICKS + 1);
  localparam logic [31:0] M_CTRL = 32'h3F000010;
  localparam logic [31:0] M_B0   = 32'h00000003;
  localparam logic [31:0] M_B1   = 32'h00070700;
  localparam logic [31:0] M_B2   = 32'h00070072;
  localparam logic [31:0] M_DAT  = 32'h003F1F1F;
  localparam logic [31:0] M_CLK  = 32'h00201F1F;

  logic [31:0]   ctrl_q, b0_q, b1_q, b2_q;
  logic [31:0]   dcfg [ND];
  logic [31:0]   ccfg [NC];
  logic [14:0]   dcode [ND];
  logic [9:0]    ccode [NC];
  logic          wait_q;
  logic [2:0]    pre_cnt;
  logic [CW-1:0] seq_cnt;

  logic [5:0] ix;
  logic       dhit, chit;
  logic [3:0] dnum;
  logic [2:0] cnum;

  assign ix = bus_addr[7:2];

  always_comb begin
    dhit = 1'b0;
    dnum = '0;
    if (ix >= 6'd5 && ix <= 6'd10) begin
      dhit = 1'b1;
      dnum = 4'(ix - 6'd5);
    end else if (ix >= 6'd14 && ix <= 6'd17) begin
      dhit = 1'b1;
      dnum = 4'(ix - 6'd8);
    end
    chit = (ix >= 6'd25) && (ix <= 6'd29);
    cnum = 3'(ix - 6'd25);
  end

  logic       wr_start, wr_clr, tick, apply;
  logic [2:0] div_last;

  assign wr_start = bus_wr && ix == 6'd0 && bus_wdata[0] && !cal_active;
  assign wr_clr   = bus_wr && ix == 6'd2 && bus_wdata[16];
  assign div_last = 3'((4'd1 << ctrl_q[25:24]) - 4'd1);
  assign tick     = pre_cnt >= div_last;
  assign apply    = cal_active && wait_q && pads_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cal_active <= 1'b0;
      cal_done   <= 1'b0;
      wait_q     <= 1'b0;
      pre_cnt    <= '0;
      seq_cnt    <= '0;
    end else begin
      if (wr_start) begin
        cal_active <= 1'b1;
        wait_q     <= 1'b0;
        pre_cnt    <= '0;
        seq_cnt    <= '0;
      end else if (cal_active && !wait_q) begin
        if (tick) begin
          pre_cnt <= '0;
          seq_cnt <= seq_cnt + 1'b1;
          if (seq_cnt == CW'(SEQ_TICKS - 1)) wait_q <= 1'b1;
        end else begin
          pre_cnt <= pre_cnt + 1'b1;
        end
      end else if (apply) begin
        cal_active <= 1'b0;
        wait_q     <= 1'b0;
      end
      if (apply) cal_done <= 1'b1;
      else if (wr_clr) cal_done <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      b0_q   <= 32'h2;
      b1_q   <= '0;
      b2_q   <= 32'h2;
      for (int i = 0; i < ND; i++) begin dcfg[i] <= '0; dcode[i] <= '0; end
      for (int i = 0; i < NC; i++) begin ccfg[i] <= '0; ccode[i] <= '0; end
    end else begin
      if (bus_wr) begin
        if (ix == 6'd0)  ctrl_q <= bus_wdata & M_CTRL;
        if (ix == 6'd22) b0_q   <= bus_wdata & M_B0;
        if (ix == 6'd23) b1_q   <= bus_wdata & M_B1;
        if (ix == 6'd24) b2_q   <= bus_wdata & M_B2;
        if (dhit) dcfg[dnum] <= bus_wdata & M_DAT;
        if (chit) ccfg[cnum] <= bus_wdata & M_CLK;
      end
      for (int i = 0; i < ND; i++)
        if (apply && dcfg[i][21])
          dcode[i] <= {dcfg[i][20:16], dcfg[i][12:8], dcfg[i][4:0]};
      for (int i = 0; i < NC; i++)
        if (apply && ccfg[i][21])
          ccode[i] <= {ccfg[i][12:8], ccfg[i][4:0]};
    end
  end

  always_comb begin
    case (ix)
      6'd0:    bus_rdata = ctrl_q;
      6'd2:    bus_rdata = {15'd0, cal_done, 15'd0, cal_active};
      6'd22:   bus_rdata = b0_q;
      6'd23:   bus_rdata = b1_q;
      6'd24:   bus_rdata = b2_q;
      default: bus_rdata = dhit ? dcfg[dnum] : (chit ? ccfg[cnum] : 32'd0);
    endcase
  end

  assign filt_len     = ctrl_q[29:26];
  assign clk_force    = ctrl_q[4];
  assign clamp_ref_en = b0_q[0];
  assign clamp_pd     = b0_q[1];
  assign drv_dn       = b1_q[18:16];
  assign drv_up       = b1_q[10:8];
  assign clamp_lvl    = b2_q[18:16];
  assign aux_lvl      = b2_q[6:4];
  assign reg_pd       = b2_q[1];

  for (genvar g = 0; g < ND; g++) begin : g_dat
    assign data_sel[g]          = dcfg[g][21];
    assign data_code[g*15 +: 15] = dcode[g];
  end
  for (genvar g = 0; g < NC; g++) begin : g_clk
    assign clk_sel[g]            = ccfg[g][21];
    assign clk_code[g*10 +: 10] = ccode[g];
  end

  AST_FALL_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_active) |-> $past(pads_idle)) else $error("idle"); // R5
  AST_FALL_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_active) |-> cal_done) else $error("done"); // R6
  AST_CODES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cal_active && pads_idle) |=> ($stable(data_code) && $stable(clk_code))) else $error("hold"); // R8
  AST_SEQ_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_cnt <= CW'(SEQ_TICKS)) else $error("range"); // R4
  AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_active && bus_wr && ix == 6'd0 && bus_wdata[0] && seq_cnt != '0) |=> seq_cnt != '0) else $error("rearm"); // R7
endmodule

// File: tb/padcal_seq_tb.sv
module padcal_seq_tb;
  localparam int T = 12;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, pads_idle = 1'b1;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic cal_active, cal_done, clk_force, clamp_pd, clamp_ref_en, reg_pd;
  logic [3:0] filt_len;
  logic [2:0] clamp_lvl, aux_lvl, drv_dn, drv_up;
  logic [9:0] data_sel;
  logic [149:0] data_code;
  logic [4:0] clk_sel;
  logic [49:0] clk_code;
  int checks = 0, fails = 0;
  logic [14:0] exp_d [10];
  logic [9:0]  exp_c [5];
  logic [31:0] cfg_d [10];
  logic [31:0] cfg_c [5];

  always #2.5 clk = ~clk;

  padcal_seq #(.SEQ_TICKS(T)) u_dut (.*);

  task automatic chk(input string r, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = 8'(idx << 2); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    bus_addr = 8'(idx << 2);
    #1 v = bus_rdata;
  endtask

  function automatic logic [31:0] mask_of(input int idx);
    if (idx == 0) return 32'h3F000010;
    if (idx == 22) return 32'h3;
    if (idx == 23) return 32'h00070700;
    if (idx == 24) return 32'h00070072;
    if ((idx >= 5 && idx <= 10) || (idx >= 14 && idx <= 17)) return 32'h003F1F1F;
    if (idx >= 25 && idx <= 29) return 32'h00201F1F;
    return 32'h0;
  endfunction

  function automatic int didx(input int i);
    return i < 6 ? 5 + i : 8 + i;
  endfunction

  task automatic run_len(input logic [1:0] p, output int n);
    wr(0, {6'd0, p, 24'd1});
    n = 0;
    if (cal_active) n = 1;
    while (cal_active && n < 5000) begin
      @(negedge clk);
      if (cal_active) n++;
    end
  endtask

  task automatic apply_model();
    for (int i = 0; i < 10; i++)
      if (cfg_d[i][21]) exp_d[i] = {cfg_d[i][20:16], cfg_d[i][12:8], cfg_d[i][4:0]};
    for (int i = 0; i < 5; i++)
      if (cfg_c[i][21]) exp_c[i] = {cfg_c[i][12:8], cfg_c[i][4:0]};
  endtask

  task automatic check_codes(input string tag);
    for (int i = 0; i < 10; i++) begin
      chk({tag, " R8 data code"}, 160'(data_code[i*15 +: 15]), 160'(exp_d[i]));
      chk({tag, " R8 data sel"}, 160'(data_sel[i]), 160'(cfg_d[i][21]));
    end
    for (int i = 0; i < 5; i++) begin
      chk({tag, " R9 clk code"}, 160'(clk_code[i*10 +: 10]), 160'(exp_c[i]));
      chk({tag, " R9 clk sel"}, 160'(clk_sel[i]), 160'(cfg_c[i][21]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, d;
    int n, idx;
    void'($urandom(32'd1234));
    for (int i = 0; i < 10; i++) begin exp_d[i] = '0; cfg_d[i] = '0; end
    for (int i = 0; i < 5; i++) begin exp_c[i] = '0; cfg_c[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 32; i++) begin
      rd(i, v);
      chk("R1 reset value", 160'(v), 160'((i == 22 || i == 24) ? 32'h2 : 32'h0));
    end
    chk("R1 power-down outputs", 160'({clamp_pd, reg_pd, cal_active, cal_done}), 160'(4'b1100));

    for (int k = 0; k < 40; k++) begin
      idx = int'($urandom % 32);
      if (idx == 2) idx = 3;
      d = $urandom;
      if (idx == 0) d[0] = 1'b0;
      wr(idx, d);
      rd(idx, v);
      chk("R2 readback", 160'(v), 160'(d & mask_of(idx)));
      if (idx == 0) wr(0, 32'h0);
    end
    for (int i = 0; i < 10; i++) begin cfg_d[i] = '0; wr(didx(i), 0); end
    for (int i = 0; i < 5; i++) begin cfg_c[i] = '0; wr(25 + i, 0); end

    wr(22, 32'h1);
    wr(23, 32'h00060200);
    wr(24, 32'h00050030);
    wr(0, 32'h28000010);
    chk("R10 bias outputs", 160'({clamp_pd, clamp_ref_en, drv_dn, drv_up, clamp_lvl, aux_lvl, reg_pd}),
        160'({1'b0, 1'b1, 3'd6, 3'd2, 3'd5, 3'd3, 1'b0}));
    chk("R10 ctrl outputs", 160'({filt_len, clk_force}), 160'({4'hA, 1'b1}));

    for (int p = 0; p < 4; p++) begin
      wr(0, {6'd0, 2'(p), 24'd1});
      chk("R3 active after start", 160'(cal_active), 160'(1));
      rd(0, v);
      chk("R3 start bit reads 0", 160'(v[0]), 160'(0));
      n = 1;
      while (cal_active && n < 5000) begin
        @(negedge clk);
        if (cal_active) n++;
      end
      chk("R4 run length", 160'(n), 160'((1 << p) * T + 1));
    end

    rd(2, v);
    chk("R6 done set", 160'(v), 160'(32'h00010000));
    wr(2, 32'h00000001);
    rd(2, v);
    chk("R6 write 0 keeps done", 160'(v), 160'(32'h00010000));
    wr(2, 32'h00010000);
    rd(2, v);
    chk("R6 write 1 clears done", 160'(v), 160'(0));

    wr(0, {6'd0, 2'd1, 24'd1});
    n = 1;
    wr(0, {6'd0, 2'd1, 24'd1});
    if (cal_active) n++;
    repeat (4) begin @(negedge clk); if (cal_active) n++; end
    wr(0, {6'd0, 2'd1, 24'd1});
    if (cal_active) n++;
    while (cal_active && n < 5000) begin
      @(negedge clk);
      if (cal_active) n++;
    end
    chk("R7 restart ignored", 160'(n), 160'(2 * T + 1));

    pads_idle = 1'b0;
    wr(0, {6'd0, 2'd0, 24'd1});
    repeat (T + 6) @(negedge clk);
    chk("R5 waits for idle", 160'(cal_active), 160'(1));
    pads_idle = 1'b1;
    @(negedge clk);
    chk("R5 falls after idle", 160'(cal_active), 160'(0));

    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 10; i++) begin
        cfg_d[i] = $urandom & 32'h003F1F1F;
        wr(didx(i), cfg_d[i]);
      end
      for (int i = 0; i < 5; i++) begin
        cfg_c[i] = $urandom & 32'h00201F1F;
        wr(25 + i, cfg_c[i]);
      end
      check_codes("before run");
      run_len(2'($urandom % 4), n);
      apply_model();
      check_codes("after run");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule